// File: doc/BRIEF.md
# Chained Serial Command Front End

This block is the serial port of an eight-channel output controller. A host drives a shift clock, a latch strobe and a data line. The block samples them in a fast system clock and owns an output-data register and a control register. It reports a 16-bit fault word that it receives from outside. Several devices can be wired in a chain: each device's serial output feeds the next device's serial input, and the clock, latch and reset lines are shared. Every device in the chain therefore sees the same strobes.

A normal write shifts a frame of 2*CH bits per device while the latch line is low, then raises the latch. The last CH bits shifted into each device land in its data register. On the same strobe, the device loads its fault word into the shift path, so the next frame carries the fault status out.

Special operations carry no opcode byte. The host sends a rhythm of latch levels instead, and the block counts shift clock pulses in four consecutive latch segments: low, high, low, high. A low segment holding exactly one pulse opens a candidate sequence. When the latch falls at the end of the fourth segment, the four counts are matched against a fixed set of patterns. The block then either arms a control write, loads a register for readback, or emits a one-cycle pulse for fault clearing or for starting the PWM phase.

Top module: `chain_serial_port`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first serial event, `data_q`, `ctrl_q` and `sdo` are 0 and no pulse appears on `fault_clr` or `pwm_go`.
- R2: Bits on `sdi` enter the shift path on each rising `sclk_in` edge, MSB first. When `latch_in` rises after a low segment whose pulse count is not exactly 1, and no sequence is pending, the last CH bits shifted in (the final bit at position 0) are copied into `data_q`.
- R3: On each such data latch, the shift path is loaded with `fault_in`, and bit 15 appears on `sdo` at once. Each following bit appears after the falling `sclk_in` edge, so `sdo` is stable across every rising edge.
- R4: Segment counts 1,2,2,3 arm a control write. The next data latch then stores the low CH bits into `ctrl_q` instead of `data_q`, leaves `data_q` unchanged, and disarms.
- R5: Segment counts 1,4,2,3 load `{ctrl_q, CH zeros}` into the shift path, and the following pulses shift it out on `sdo`, MSB first.
- R6: Segment counts 1,4,4,3 load `{data_q, CH zeros}` into the shift path, and the following pulses shift it out on `sdo`, MSB first.
- R7: Segment counts 1,2,4,3 produce exactly one `fault_clr` pulse one system clock wide.
- R8: Segment counts 1,6,6,3 produce exactly one `pwm_go` pulse one system clock wide. `fault_clr` and `pwm_go` are never high together.
- R9: A four-segment sequence that opens with a one-pulse low segment but matches no pattern has no effect on `data_q`, `ctrl_q` or the pulse outputs. The next latch rise is treated as a normal data latch.
- R10: A bit shifted in on `sdi` reappears on `sdo` 2*CH pulses later, which lets devices be chained.
- R11: Pulling `rst_n` low in the middle of a frame clears `data_q`, `ctrl_q`, `sdo`, the armed control write and any partly counted sequence at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial shift clock from the host |
| latch_in | input | 1 | Latch strobe; its levels also frame command segments |
| sdi | input | 1 | Serial data in |
| fault_in | input | 2*CH | Fault word from the protection logic, loaded on each data latch |
| sdo | output | 1 | Serial data out to the host or to the next device |
| data_q | output | CH | Output-data register, one bit per channel |
| ctrl_q | output | CH | Control register |
| fault_clr | output | 1 | One-cycle request to clear the fault word |
| pwm_go | output | 1 | One-cycle request to start the PWM phase |

## Verification
The bench builds the block with CH = 8 and two synchroniser stages. This gives the full 16-bit frame, the 8-bit readback halves, and a 3-bit segment counter that saturates at 7. Random segment counts drawn from 0 to 7 therefore reach both the saturation value and every valid pattern as well as near misses. Random frames, readbacks and command rhythms check every `sdo` bit against a bench model of the shift path, including the pass-through used for chaining. Directed cases cover the one-pulse opening segment, unmatched sequences and a reset in the middle of a frame.

// File: rtl/chain_pkg.sv
package chain_pkg;
  localparam int CNT_W = 3;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_WR_CTRL, CMD_RD_CTRL, CMD_RD_DATA, CMD_FLT_CLR, CMD_PWM_GO
  } cmd_e;

  // Map the three counts that follow the one-pulse opener to an operation.
  function automatic cmd_e match_cmd(input logic [CNT_W-1:0] c2,
                                     input logic [CNT_W-1:0] c3,
                                     input logic [CNT_W-1:0] c4);
    cmd_e r;
    r = CMD_NONE;
    if (c4 == CNT_W'(3)) begin
      if      (c2 == CNT_W'(2) && c3 == CNT_W'(2)) r = CMD_WR_CTRL;
      else if (c2 == CNT_W'(4) && c3 == CNT_W'(2)) r = CMD_RD_CTRL;
      else if (c2 == CNT_W'(4) && c3 == CNT_W'(4)) r = CMD_RD_DATA;
      else if (c2 == CNT_W'(2) && c3 == CNT_W'(4)) r = CMD_FLT_CLR;
      else if (c2 == CNT_W'(6) && c3 == CNT_W'(6)) r = CMD_PWM_GO;
    end
    return r;
  endfunction
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int N = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/segment_decoder.sv
module segment_decoder
  import chain_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_rise,
  input  logic latch_rise,
  input  logic latch_fall,
  output logic commit,
  output logic cmd_valid,
  output cmd_e cmd
);
  logic [CNT_W-1:0] cnt, c2, c3;
  logic [1:0]       part;
  cmd_e             matched;

  always_comb begin
    matched   = match_cmd(c2, c3, cnt);
    commit    = latch_rise && (part == 2'd0) && (cnt != CNT_W'(1));
    cmd_valid = latch_fall && (part == 2'd3) && (matched != CMD_NONE);
    cmd       = matched;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      c2   <= '0;
      c3   <= '0;
      part <= 2'd0;
    end else begin
      if (latch_rise || latch_fall) cnt <= '0;
      else if (sclk_rise && cnt != '1) cnt <= cnt + CNT_W'(1);
      if (latch_rise) begin
        if (part == 2'd0 && cnt == CNT_W'(1)) part <= 2'd1;
        else if (part == 2'd2) begin
          c3   <= cnt;
          part <= 2'd3;
        end
      end else if (latch_fall) begin
        if (part == 2'd1) begin
          c2   <= cnt;
          part <= 2'd2;
        end else if (part == 2'd3) part <= 2'd0;
      end
    end
  end

  assert_part_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(latch_rise || latch_fall) |=> $stable(part));
  assert_one_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit, cmd_valid}));
endmodule

// File: rtl/shift_path.sv
module shift_path #(
  parameter int SW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          sdi_s,
  input  logic          load,
  input  logic [SW-1:0] load_val,
  output logic [LW-1:0] low_q,
  output logic          sdo
);
  logic [SW-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      sdo <= 1'b0;
    end else begin
      if (load)           sh <= load_val;
      else if (sclk_rise) sh <= {sh[SW-2:0], sdi_s};
      if (load)           sdo <= load_val[SW-1];
      else if (sclk_fall) sdo <= sh[SW-1];
    end
  end

  assign low_q = sh[LW-1:0];

  assert_sdo_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_fall || load) |=> $stable(sdo));
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !load) |=> low_q[0] == $past(sdi_s));
endmodule

// File: rtl/chain_serial_port.sv
module chain_serial_port
  import chain_pkg::*;
#(
  parameter int CH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk_in,
  input  logic            latch_in,
  input  logic            sdi,
  input  logic [2*CH-1:0] fault_in,
  output logic            sdo,
  output logic [CH-1:0]   data_q,
  output logic [CH-1:0]   ctrl_q,
  output logic            fault_clr,
  output logic            pwm_go
);
  localparam int SW = 2 * CH;

  logic [2:0] raw, s_now, s_prev;
  logic sclk_rise, sclk_fall, latch_rise, latch_fall;
  logic commit, cmd_valid, load, armed;
  cmd_e cmd;
  logic [SW-1:0] load_val;
  logic [CH-1:0] word;

  assign raw = {latch_in, sclk_in, sdi};

  line_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(s_now));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_prev <= '0;
    else        s_prev <= s_now;
  end

  assign sclk_rise  =  s_now[1] & ~s_prev[1];
  assign sclk_fall  = ~s_now[1] &  s_prev[1];
  assign latch_rise =  s_now[2] & ~s_prev[2];
  assign latch_fall = ~s_now[2] &  s_prev[2];

  segment_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise),
    .latch_rise(latch_rise), .latch_fall(latch_fall),
    .commit(commit), .cmd_valid(cmd_valid), .cmd(cmd));

  always_comb begin
    load     = commit;
    load_val = fault_in;
    if (cmd_valid && cmd == CMD_RD_CTRL) begin
      load     = 1'b1;
      load_val = {ctrl_q, {CH{1'b0}}};
    end else if (cmd_valid && cmd == CMD_RD_DATA) begin
      load     = 1'b1;
      load_val = {data_q, {CH{1'b0}}};
    end
  end

  shift_path #(.SW(SW), .LW(CH)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .sdi_s(s_now[0]), .load(load), .load_val(load_val),
    .low_q(word), .sdo(sdo));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q    <= '0;
      ctrl_q    <= '0;
      armed     <= 1'b0;
      fault_clr <= 1'b0;
      pwm_go    <= 1'b0;
    end else begin
      fault_clr <= cmd_valid && (cmd == CMD_FLT_CLR);
      pwm_go    <= cmd_valid && (cmd == CMD_PWM_GO);
      if (commit) begin
        if (armed) ctrl_q <= word;
        else       data_q <= word;
        armed <= 1'b0;
      end else if (cmd_valid && cmd == CMD_WR_CTRL) begin
        armed <= 1'b1;
      end
    end
  end

  assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(data_q));
  assert_ctrl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && armed) |=> $stable(ctrl_q));
  assert_clr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_clr |=> !fault_clr);
  assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fault_clr, pwm_go}));
  assert_pwm_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_go |=> !pwm_go);
endmodule

// File: tb/sim_chain_serial_port.sv
module sim_chain_serial_port;
  localparam int CH = 8;
  localparam int SW = 2 * CH;

  logic clk = 1'b0, rst_n = 1'b0, sclk_in = 1'b0, latch_in = 1'b0, sdi = 1'b0;
  logic [SW-1:0] fault_in = '0;
  logic sdo, fault_clr, pwm_go;
  logic [CH-1:0] data_q, ctrl_q;

  chain_serial_port #(.CH(CH), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .latch_in(latch_in), .sdi(sdi),
    .fault_in(fault_in), .sdo(sdo), .data_q(data_q), .ctrl_q(ctrl_q),
    .fault_clr(fault_clr), .pwm_go(pwm_go));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, clr_seen = 0, pwm_seen = 0, both_seen = 0;
  bit done = 0;
  string tag = "R3";

  // bench model
  logic [SW-1:0] m_sh = '0;
  logic [CH-1:0] m_data = '0, m_ctrl = '0;
  bit m_armed = 0;
  int m_part = 0, m_seg = 0, m_c2 = 0, m_c3 = 0, m_clr = 0, m_pwm = 0;

  always @(negedge clk) begin
    if (fault_clr) clr_seen++;
    if (pwm_go) pwm_seen++;
    if (fault_clr && pwm_go) both_seen++;
  end

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  // 1 write ctrl, 2 read ctrl, 3 read data, 4 fault clear, 5 pwm start
  function automatic int op_of(input int a, input int b, input int c);
    if (c != 3) return 0;
    case ({a[7:0], b[7:0]})
      16'h0202: return 1;
      16'h0402: return 2;
      16'h0404: return 3;
      16'h0204: return 4;
      16'h0606: return 5;
      default:  return 0;
    endcase
  endfunction

  task automatic pulse(input logic b);
    @(negedge clk) sdi = b;
    repeat (4) @(negedge clk);
    check(tag, sdo, m_sh[SW-1]);
    sclk_in = 1'b1;
    repeat (4) @(negedge clk);
    sclk_in = 1'b0;
    repeat (4) @(negedge clk);
    m_sh = {m_sh[SW-2:0], b};
    m_seg++;
  endtask

  task automatic lat(input logic v);
    int k;
    @(negedge clk) latch_in = v;
    repeat (6) @(negedge clk);
    if (v) begin
      if (m_part == 0) begin
        if (m_seg == 1) m_part = 1;
        else begin
          if (m_armed) m_ctrl = m_sh[CH-1:0];
          else         m_data = m_sh[CH-1:0];
          m_armed = 0;
          m_sh = fault_in;
        end
      end else if (m_part == 2) begin
        m_c3 = m_seg; m_part = 3;
      end
    end else begin
      if (m_part == 1) begin
        m_c2 = m_seg; m_part = 2;
      end else if (m_part == 3) begin
        k = op_of(m_c2, m_c3, m_seg);
        m_part = 0;
        if (k == 1) m_armed = 1;
        if (k == 2) m_sh = {m_ctrl, {CH{1'b0}}};
        if (k == 3) m_sh = {m_data, {CH{1'b0}}};
        if (k == 4) m_clr++;
        if (k == 5) m_pwm++;
      end
    end
    m_seg = 0;
  endtask

  task automatic frame(input logic [SW-1:0] w, input logic [SW-1:0] f);
    fault_in = f;
    for (int i = SW - 1; i >= 0; i--) pulse(w[i]);
    lat(1'b1);
    lat(1'b0);
  endtask

  task automatic seq(input int a, input int b, input int c);
    pulse(1'($urandom));
    lat(1'b1);
    for (int i = 0; i < a; i++) pulse(1'($urandom));
    lat(1'b0);
    for (int i = 0; i < b; i++) pulse(1'($urandom));
    lat(1'b1);
    for (int i = 0; i < c; i++) pulse(1'($urandom));
    lat(1'b0);
  endtask

  task automatic readout();
    for (int i = 0; i < SW; i++) pulse(1'b0);
  endtask

  task automatic state(input string t);
    check({t, " data"}, data_q, m_data);
    check({t, " ctrl"}, ctrl_q, m_ctrl);
    check({t, " clr"}, clr_seen, m_clr);
    check({t, " pwm"}, pwm_seen, m_pwm);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    m_sh = '0; m_data = '0; m_ctrl = '0; m_armed = 0;
    m_part = 0; m_seg = 0;
    check("R11 data", data_q, 0);
    check("R11 ctrl", ctrl_q, 0);
    check("R11 sdo", sdo, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int op;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    check("R1 data", data_q, 0);
    check("R1 ctrl", ctrl_q, 0);
    check("R1 sdo", sdo, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    state("R1");

    tag = "R2/R3";
    frame(16'h33A5, 16'hBEEF);
    check("R2 data", data_q, 8'hA5);
    tag = "R3/R10";
    frame(16'h0F3C, 16'h1234);
    check("R2 second data", data_q, 8'h3C);

    tag = "R4";
    seq(2, 2, 3);
    frame(16'h0096, 16'h0);
    state("R4");
    check("R4 ctrl", ctrl_q, 8'h96);

    tag = "R5";
    seq(4, 2, 3);
    readout();
    frame(16'h0011, 16'hA5A5);
    state("R5");

    tag = "R6";
    seq(4, 4, 3);
    readout();
    frame(16'h0022, 16'h5A5A);
    state("R6");

    tag = "R7";
    seq(2, 4, 3);
    state("R7");
    check("R7 one pulse", clr_seen, 1);

    tag = "R8";
    seq(6, 6, 3);
    state("R8");
    check("R8 one pulse", pwm_seen, 1);

    tag = "R9";
    seq(2, 2, 4);
    state("R9 near miss");
    seq(8, 2, 3);
    state("R9 saturated");
    frame(16'h00C3, 16'h0);
    state("R9 after");
    check("R9 data", data_q, 8'hC3);

    tag = "R11";
    frame(16'h0077, 16'h0);
    seq(2, 2, 3);
    for (int i = 0; i < 5; i++) pulse(1'b1);
    do_reset();
    frame(16'h0044, 16'hC001);
    state("R11 after");
    check("R11 disarmed ctrl", ctrl_q, 0);

    for (int n = 0; n < 120; n++) begin
      op = $urandom % 7;
      case (op)
        0, 1: begin tag = "R2/R10"; frame(16'($urandom), 16'($urandom)); end
        2: begin tag = "R4"; seq(2, 2, 3); frame(16'($urandom), 16'($urandom)); end
        3: begin tag = "R5"; seq(4, 2, 3); readout(); frame(16'($urandom), 16'($urandom)); end
        4: begin tag = "R6"; seq(4, 4, 3); readout(); frame(16'($urandom), 16'($urandom)); end
        5: begin tag = "R7/R8"; if ($urandom % 2) seq(2, 4, 3); else seq(6, 6, 3); end
        default: begin
          tag = "R9";
          seq($urandom % 8, $urandom % 8, $urandom % 8);
          frame(16'($urandom), 16'($urandom));
        end
      endcase
      state(tag);
    end
    check("R8 never together", both_seen, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule